// File: doc/BRIEF.md
# PRBS-15 Pattern Source and Monitor with Decimal Error Insertion

This block is a bit-serial test pattern engine for one E1 channel. It holds one PRBS-15 generator (polynomial x^15 + x^14 + 1) and one pattern monitor. Two data paths cross it. The transmit path runs from the backplane to the line. The receive path runs from the line to the backplane. Each path carries a data bit and a one-cycle valid strobe per bit.

A static swap input places the generator and the monitor. With swap low, the generator replaces the line-side transmit data and the monitor watches the line receive data. With swap high, the generator replaces the data sent to the receive backplane and the monitor watches the transmit backplane data. The path that is not generating passes its data through.

A two-bit rate input inverts single generated bits at a fixed decimal interval. The interval is one bit per thousand or one bit per million. The monitor seeds itself from the incoming stream and then reports pattern lock.

Top module: `prbs_tester`

## Requirements
- R1: During reset and in the first cycle after it, every output is 0: both data outputs, both valid outputs and `lock_o`. The generator register starts at all ones, so the first generated bit is 0.
- R2: With `swap_i`=0, each `bp_tx_vld_i` strobe makes the generator take one step. One cycle later `line_tx_data_o` carries the PRBS-15 bit, where new bit = (bit 15 back) XOR (bit 14 back). `line_tx_vld_o` repeats `bp_tx_vld_i` one cycle late. Without a strobe, `line_tx_data_o` is 0.
- R3: With `swap_i`=0, `bp_rx_data_o` and `bp_rx_vld_o` repeat `line_rx_data_i` and `line_rx_vld_i` one cycle late, unchanged.
- R4: With `swap_i`=1, each `line_rx_vld_i` strobe makes the generator take one step, and `bp_rx_data_o` carries the generated bit one cycle later. `line_tx_data_o` repeats `bp_tx_data_i` one cycle late.
- R5: The monitor takes data only from the line receive input when `swap_i`=0, and only from the transmit backplane input when `swap_i`=1. A valid pattern on the other input never causes lock.
- R6: The monitor loads 15 received bits and then needs 32 consecutive matching bits. `lock_o` rises in the cycle after the 47th valid bit of a clean stream. It stays low after the 46th bit.
- R7: Once locked, the monitor predicts the pattern on its own and counts mismatches in consecutive 64-bit blocks, starting at lock. Five mismatches in a block keep lock. The sixth mismatch in one block clears `lock_o` in the cycle after that bit.
- R8: Rate code 01 inverts every 1000th generated bit (`ERR_LO`), counted from reset or from the last change of the controls.
- R9: Rate code 10 inverts every `ERR_HI`-th generated bit. The default is 1,000,000.
- R10: Rate codes 00 and 11 insert no errors.
- R11: The error interval counter advances only on valid strobes of the path that is generating. It restarts from zero in the first cycle in which `rate_i` or `swap_i` differs from its value in the cycle before.
- R12: The generator state is never all zeros, so its output never shows 15 zeros in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_i | input | 1 | 0: generate to line, monitor line; 1: generate to backplane, monitor backplane |
| rate_i | input | 2 | Error rate code: 00 off, 01 per ERR_LO, 10 per ERR_HI, 11 off |
| bp_tx_vld_i | input | 1 | Transmit backplane bit strobe |
| bp_tx_data_i | input | 1 | Transmit backplane data bit |
| line_rx_vld_i | input | 1 | Line receive bit strobe |
| line_rx_data_i | input | 1 | Line receive data bit |
| line_tx_vld_o | output | 1 | Line transmit bit strobe |
| line_tx_data_o | output | 1 | Line transmit data bit |
| bp_rx_vld_o | output | 1 | Receive backplane bit strobe |
| bp_rx_data_o | output | 1 | Receive backplane data bit |
| lock_o | output | 1 | Monitor pattern lock |

## Verification
The pass-through properties assume that `swap_i` holds steady across the cycle in which a bit enters and the cycle in which it leaves. The restart rule assumes that rate and swap changes do not coincide with a generating strobe. The stimulus therefore changes the controls only after idle cycles with both strobes low. Each strobe lasts one cycle and is followed by an idle cycle. This keeps the data being checked separate from any control change.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int PRBS_W = 15;

  typedef enum logic [1:0] {
    RATE_NONE  = 2'b00,
    RATE_LOW   = 2'b01,
    RATE_HIGH  = 2'b10,
    RATE_NONE2 = 2'b11
  } rate_e;

  // Feedback bit for x^15 + x^14 + 1: oldest bit xor second oldest
  function automatic logic prbs_fb(input logic [PRBS_W-1:0] s);
    return s[PRBS_W-1] ^ s[PRBS_W-2];
  endfunction

  // Shift a new bit in at the young end
  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s, input logic b);
    return {s[PRBS_W-2:0], b};
  endfunction

  // Interval in strobes for a rate code, 0 meaning no insertion
  function automatic int unsigned rate_period(input logic [1:0] code,
                                              input int unsigned lo,
                                              input int unsigned hi);
    case (rate_e'(code))
      RATE_LOW:  return lo;
      RATE_HIGH: return hi;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic              bit_o,
  output logic [PRBS_W-1:0] state_o
);
  logic [PRBS_W-1:0] st;

  assign bit_o   = prbs_fb(st);
  assign state_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n)     st <= '1;
    else if (adv_i) st <= prbs_step(st, prbs_fb(st));
  end
endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject
  import prbs_pkg::*;
#(
  parameter int unsigned ERR_LO = 1000,
  parameter int unsigned ERR_HI = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_i,
  input  logic       swap_i,
  input  logic       strobe_i,
  output logic       flip_o
);
  localparam int unsigned MAXP = (ERR_HI > ERR_LO) ? ERR_HI : ERR_LO;
  localparam int CW = $clog2(MAXP + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    rate_q;
  logic          swap_q;
  logic          chg;
  logic [31:0]   period;
  logic          at_end;

  assign chg    = (rate_i != rate_q) || (swap_i != swap_q);
  assign period = rate_period(rate_i, ERR_LO, ERR_HI);
  assign at_end = (period != 0) && (cnt == CW'(period - 1));
  assign flip_o = strobe_i && !chg && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rate_q <= 2'b00;
      swap_q <= 1'b0;
    end else begin
      rate_q <= rate_i;
      swap_q <= swap_i;
      if (chg)                               cnt <= '0;
      else if (strobe_i && period != 0)      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/prbs_mon.sv
module prbs_mon
  import prbs_pkg::*;
#(
  parameter int LOCK_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic data_i,
  output logic lock_o,
  output logic mis_o
);
  localparam int RW = $clog2(LOCK_RUN);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(LOSS);
  localparam int FW = $clog2(PRBS_W + 1);

  logic [PRBS_W-1:0] m;
  logic [FW-1:0]     fill;
  logic [RW-1:0]     run;
  logic [WW-1:0]     win;
  logic [EW-1:0]     errs;
  logic              locked;
  logic              pred, seeded, mis;

  assign pred   = prbs_fb(m);
  assign seeded = (fill == FW'(PRBS_W));
  assign mis    = (data_i != pred);
  assign mis_o  = vld_i && mis && (locked || seeded);
  assign lock_o = locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m <= '0; fill <= '0; run <= '0; win <= '0; errs <= '0; locked <= 1'b0;
    end else if (vld_i) begin
      if (!locked) begin
        m <= prbs_step(m, data_i);
        if (!seeded) begin
          fill <= fill + 1'b1;
        end else if (!mis && m != '0) begin
          if (run == RW'(LOCK_RUN - 1)) begin
            locked <= 1'b1;
            run    <= '0;
            win    <= '0;
            errs   <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end else begin
        m <= prbs_step(m, pred);
        if (mis && errs == EW'(LOSS - 1)) begin
          locked <= 1'b0;
          fill   <= '0;
          run    <= '0;
        end else if (win == WW'(WIN - 1)) begin
          win  <= '0;
          errs <= '0;
        end else begin
          win  <= win + 1'b1;
          errs <= errs + EW'(mis);
        end
      end
    end
  end
endmodule

// File: rtl/prbs_tester.sv
module prbs_tester
  import prbs_pkg::*;
#(
  parameter int unsigned ERR_LO   = 1000,
  parameter int unsigned ERR_HI   = 1000000,
  parameter int          LOCK_RUN = 32,
  parameter int          WIN      = 64,
  parameter int          LOSS     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap_i,
  input  logic [1:0] rate_i,
  input  logic       bp_tx_vld_i,
  input  logic       bp_tx_data_i,
  input  logic       line_rx_vld_i,
  input  logic       line_rx_data_i,
  output logic       line_tx_vld_o,
  output logic       line_tx_data_o,
  output logic       bp_rx_vld_o,
  output logic       bp_rx_data_o,
  output logic       lock_o
);
  logic              gen_adv, gen_bit, gen_out;
  logic [PRBS_W-1:0] gen_state;
  logic              inj_flip;
  logic              mon_vld, mon_dat, mon_mis;

  assign gen_adv = swap_i ? line_rx_vld_i : bp_tx_vld_i;
  assign mon_vld = swap_i ? bp_tx_vld_i  : line_rx_vld_i;
  assign mon_dat = swap_i ? bp_tx_data_i : line_rx_data_i;
  assign gen_out = gen_bit ^ inj_flip;

  prbs_gen u_gen (
    .clk(clk), .rst_n(rst_n), .adv_i(gen_adv), .bit_o(gen_bit), .state_o(gen_state)
  );

  prbs_err_inject #(.ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_inj (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .swap_i(swap_i),
    .strobe_i(gen_adv), .flip_o(inj_flip)
  );

  prbs_mon #(.LOCK_RUN(LOCK_RUN), .WIN(WIN), .LOSS(LOSS)) u_mon (
    .clk(clk), .rst_n(rst_n), .vld_i(mon_vld), .data_i(mon_dat),
    .lock_o(lock_o), .mis_o(mon_mis)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_tx_vld_o  <= 1'b0;
      line_tx_data_o <= 1'b0;
      bp_rx_vld_o    <= 1'b0;
      bp_rx_data_o   <= 1'b0;
    end else begin
      line_tx_vld_o  <= bp_tx_vld_i;
      bp_rx_vld_o    <= line_rx_vld_i;
      line_tx_data_o <= swap_i ? bp_tx_data_i : (bp_tx_vld_i & gen_out);
      bp_rx_data_o   <= swap_i ? (line_rx_vld_i & gen_out) : line_rx_data_i;
    end
  end
endmodule

// File: rtl/prbs_tester_chk.sv
module prbs_tester_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        swap_i,
  input logic [1:0]  rate_i,
  input logic        bp_tx_vld_i,
  input logic        bp_tx_data_i,
  input logic        line_rx_vld_i,
  input logic        line_rx_data_i,
  input logic        line_tx_vld_o,
  input logic        line_tx_data_o,
  input logic        bp_rx_vld_o,
  input logic        bp_rx_data_o,
  input logic        lock_o,
  input logic [14:0] gen_state,
  input logic        inj_flip,
  input logic        mon_mis
);
  p_gen_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0);

  p_tx_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> line_tx_vld_o == $past(bp_tx_vld_i));

  p_idle_gen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_i && !bp_tx_vld_i) |=> !line_tx_data_o);

  p_rx_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> (bp_rx_data_o == $past(line_rx_data_i)) && (bp_rx_vld_o == $past(line_rx_vld_i)));

  p_tx_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> line_tx_data_o == $past(bp_tx_data_i));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !mon_mis) |=> lock_o);

  p_no_flip_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == 2'b00 || rate_i == 2'b11) |-> !inj_flip);

  p_flip_on_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inj_flip |-> (swap_i ? line_rx_vld_i : bp_tx_vld_i));
endmodule

bind prbs_tester prbs_tester_chk u_chk (
  .clk(clk), .rst_n(rst_n), .swap_i(swap_i), .rate_i(rate_i),
  .bp_tx_vld_i(bp_tx_vld_i), .bp_tx_data_i(bp_tx_data_i),
  .line_rx_vld_i(line_rx_vld_i), .line_rx_data_i(line_rx_data_i),
  .line_tx_vld_o(line_tx_vld_o), .line_tx_data_o(line_tx_data_o),
  .bp_rx_vld_o(bp_rx_vld_o), .bp_rx_data_o(bp_rx_data_o), .lock_o(lock_o),
  .gen_state(gen_state), .inj_flip(inj_flip), .mon_mis(mon_mis)
);

// File: tb/tb_prbs_tester.sv
module tb_prbs_tester;
  localparam int HI = 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap = 1'b0;
  logic [1:0] rate = 2'b00;
  logic tvld = 1'b0, tdat = 1'b0, rvld = 1'b0, rdat = 1'b0;
  logic line_tx_vld_o, line_tx_data_o, bp_rx_vld_o, bp_rx_data_o, lock_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [14:0] gq;
  logic [14:0] mq;
  int kcnt;
  int per;
  int zrun, zmax;

  always #4 clk = ~clk;

  prbs_tester #(.ERR_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .swap_i(swap), .rate_i(rate),
    .bp_tx_vld_i(tvld), .bp_tx_data_i(tdat),
    .line_rx_vld_i(rvld), .line_rx_data_i(rdat),
    .line_tx_vld_o(line_tx_vld_o), .line_tx_data_o(line_tx_data_o),
    .bp_rx_vld_o(bp_rx_vld_o), .bp_rx_data_o(bp_rx_data_o), .lock_o(lock_o)
  );

  // Reference sequence: q[0] is the oldest bit, new bits enter at q[14]
  function automatic logic ref_bit(input logic [14:0] q);
    return q[0] ^ q[1];
  endfunction
  function automatic logic [14:0] ref_adv(input logic [14:0] q);
    return {q[0] ^ q[1], q[14:1]};
  endfunction
  function automatic int code_period(input logic [1:0] c);
    if (c == 2'b01) return 1000;
    if (c == 2'b10) return HI;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tvld = 0; rvld = 0; tdat = 0; rdat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gq = '1; mq = '1; kcnt = 0; per = code_period(rate);
  endtask

  task automatic set_ctrl(input logic s, input logic [1:0] r);
    @(negedge clk);
    swap = s; rate = r;
    repeat (2) @(negedge clk);
    kcnt = 0; per = code_period(r);
  endtask

  task automatic run_gen(input bit via_rx, input int n, inout int errs);
    for (int i = 0; i < n; i++) begin
      logic expb, obs, vo;
      kcnt++;
      expb = ref_bit(gq) ^ (per != 0 && (kcnt % per) == 0);
      gq = ref_adv(gq);
      @(negedge clk);
      if (via_rx) begin rvld = 1; rdat = 0; end else begin tvld = 1; tdat = 1; end
      @(negedge clk);
      rvld = 0; tvld = 0;
      obs = via_rx ? bp_rx_data_o : line_tx_data_o;
      vo  = via_rx ? bp_rx_vld_o : line_tx_vld_o;
      if (obs !== expb || vo !== 1'b1) errs++;
      if (obs == 1'b0) zrun++; else zrun = 0;
      if (zrun > zmax) zmax = zrun;
    end
  endtask

  task automatic feed_mon(input bit via_tx, input bit flip);
    logic b;
    b = ref_bit(mq) ^ flip;
    mq = ref_adv(mq);
    @(negedge clk);
    if (via_tx) begin tvld = 1; tdat = b; end else begin rvld = 1; rdat = b; end
    @(negedge clk);
    tvld = 0; rvld = 0;
  endtask

  task automatic t_reset();
    rate = 2'b00; swap = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check({line_tx_vld_o, line_tx_data_o, bp_rx_vld_o, bp_rx_data_o, lock_o} == 5'b0,
          "R1 outputs in reset", {line_tx_vld_o, line_tx_data_o, bp_rx_vld_o, bp_rx_data_o, lock_o}, 0);
    do_reset();
    @(negedge clk);
    check({line_tx_vld_o, line_tx_data_o, bp_rx_vld_o, bp_rx_data_o, lock_o} == 5'b0,
          "R1 outputs after reset", {line_tx_vld_o, line_tx_data_o, bp_rx_vld_o, bp_rx_data_o, lock_o}, 0);
  endtask

  task automatic t_gen_line();
    int e = 0;
    rate = 2'b00; swap = 0; do_reset();
    zrun = 0; zmax = 0;
    run_gen(0, 400, e);
    check(e == 0, "R2 line transmit PRBS", e, 0);
    check(zmax < 15, "R12 no 15-zero run", zmax, 14);
    @(negedge clk);
    check(line_tx_data_o == 1'b0, "R2 idle output zero", line_tx_data_o, 0);
  endtask

  task automatic t_pass_rx();
    int e = 0;
    swap = 0; rate = 2'b00; do_reset();
    for (int i = 0; i < 50; i++) begin
      logic b;
      b = ((i * 7) % 3) == 1;
      @(negedge clk); rvld = 1; rdat = b;
      @(negedge clk); rvld = 0;
      if (bp_rx_data_o !== b || bp_rx_vld_o !== 1'b1) e++;
    end
    check(e == 0, "R3 receive pass-through", e, 0);
  endtask

  task automatic t_swap();
    int e = 0, p = 0;
    swap = 1; rate = 2'b00; do_reset();
    run_gen(1, 300, e);
    check(e == 0, "R4 backplane PRBS", e, 0);
    for (int i = 0; i < 50; i++) begin
      logic b;
      b = ((i * 5) % 4) < 2;
      @(negedge clk); tvld = 1; tdat = b;
      @(negedge clk); tvld = 0;
      if (line_tx_data_o !== b || line_tx_vld_o !== 1'b1) p++;
    end
    check(p == 0, "R4 transmit pass-through", p, 0);
  endtask

  task automatic t_mon_sel();
    swap = 0; rate = 2'b00; do_reset();
    for (int i = 0; i < 100; i++) feed_mon(1, 0);
    check(lock_o == 1'b0, "R5 no lock from unwatched input", lock_o, 0);
    set_ctrl(1, 2'b00);
    mq = '1;
    for (int i = 0; i < 100; i++) feed_mon(1, 0);
    check(lock_o == 1'b1, "R5 lock on backplane input when swapped", lock_o, 1);
  endtask

  task automatic t_lock_drop();
    swap = 0; rate = 2'b00; do_reset();
    for (int i = 1; i <= 46; i++) feed_mon(0, 0);
    check(lock_o == 1'b0, "R6 no lock after 46 bits", lock_o, 0);
    feed_mon(0, 0);
    check(lock_o == 1'b1, "R6 lock after 47 bits", lock_o, 1);
    for (int i = 48; i <= 111; i++) feed_mon(0, (i % 10) == 0 && i <= 90);
    check(lock_o == 1'b1, "R7 five errors keep lock", lock_o, 1);
    for (int i = 112; i <= 140; i++) feed_mon(0, (i % 5) == 0 && i >= 120);
    check(lock_o == 1'b1, "R7 lock held at five errors", lock_o, 1);
    for (int i = 141; i <= 145; i++) feed_mon(0, i == 145);
    check(lock_o == 1'b0, "R7 sixth error drops lock", lock_o, 0);
  endtask

  task automatic t_rate_lo();
    int e = 0;
    swap = 0; rate = 2'b01; do_reset();
    run_gen(0, 2100, e);
    check(e == 0, "R8 one per thousand", e, 0);
  endtask

  task automatic t_rate_hi();
    int e = 0;
    swap = 0; rate = 2'b10; do_reset();
    run_gen(0, 5100, e);
    check(e == 0, "R9 one per ERR_HI", e, 0);
  endtask

  task automatic t_rate_off();
    int e = 0;
    swap = 0; rate = 2'b11; do_reset();
    run_gen(0, 2100, e);
    check(e == 0, "R10 code 11 clean", e, 0);
    e = 0;
    rate = 2'b00; do_reset();
    run_gen(0, 2100, e);
    check(e == 0, "R10 code 00 clean", e, 0);
  endtask

  task automatic t_count_gate();
    int e = 0;
    swap = 0; rate = 2'b01; do_reset();
    run_gen(0, 600, e);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk); rvld = 1; rdat = i[0];
      @(negedge clk); rvld = 0;
    end
    run_gen(0, 500, e);
    check(e == 0, "R11 inactive strobes not counted", e, 0);
    e = 0;
    run_gen(0, 700, e);
    set_ctrl(0, 2'b11);
    set_ctrl(0, 2'b01);
    run_gen(0, 1100, e);
    check(e == 0, "R11 restart on rate change", e, 0);
    e = 0;
    run_gen(0, 300, e);
    set_ctrl(1, 2'b01);
    set_ctrl(0, 2'b01);
    run_gen(0, 1100, e);
    check(e == 0, "R11 restart on swap change", e, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_gen_line();
    t_pass_rx();
    t_swap();
    t_mon_sel();
    t_lock_drop();
    t_rate_lo();
    t_rate_hi();
    t_rate_off();
    t_count_gate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule